// File: doc/BRIEF.md
# Z80 Banked ROM Address Mapper

This block sits between a Z80-style 16-bit address bus and a 19-bit ROM address bus. The lower half of the CPU space is passed through to the ROM unchanged. The upper half holds four switchable windows of 16KiB, 8KiB, 4KiB and 2KiB. Each window has its own bank register, and that register supplies the high ROM address bits while the window is addressed. CPU addresses above the 2KiB window are unmapped.

Bank registers are loaded without a data bus. While the mode input is high, the console-decoded strobe falls and then rises. At the rising edge the upper address byte is stored as the bank number, and the two lowest address bits pick the window it belongs to. Translation always runs, whatever the mode input is. The translated address and a ROM-select flag come out registered, one clock after the address is sampled.

Top module: `zbank_mapper`

## Requirements
- R1: CPU addresses 0x0000 to 0x7FFF drive rom_addr equal to the CPU address with zero upper bits, and rom_sel high.
- R2: CPU addresses 0x8000 to 0xBFFF (16KiB window, select code 2'b11) drive rom_addr = {bank16[4:0], cpu_addr[13:0]} with rom_sel high.
- R3: CPU addresses 0xC000 to 0xDFFF (8KiB window, select code 2'b10) drive rom_addr = {bank8[5:0], cpu_addr[12:0]} with rom_sel high.
- R4: CPU addresses 0xE000 to 0xEFFF (4KiB window, select code 2'b01) drive rom_addr = {bank4[6:0], cpu_addr[11:0]} with rom_sel high.
- R5: CPU addresses 0xF000 to 0xF7FF (2KiB window, select code 2'b00) drive rom_addr = {bank2[7:0], cpu_addr[10:0]} with rom_sel high.
- R6: CPU addresses 0xF800 to 0xFFFF drive rom_addr to zero and rom_sel low.
- R7: A bank register is written when cfg_strobe_n rises after a fall, with cfg_mode high at both edges. The value written is cpu_addr[15:8], sampled at the rising edge, and the target window is cpu_addr[1:0].
- R8: A strobe pulse with cfg_mode low at its falling edge or at its rising edge changes no bank register.
- R9: A synchronous high rst clears every bank register and drives rom_addr to zero and rom_sel low.
- R10: rom_addr and rom_sel follow cpu_addr with exactly one clock of latency.
- R11: A configuration write changes only the bank register of the selected window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address; during configuration it also carries the bank value (high byte) and the window code (bits 1:0) |
| cfg_mode | input | 1 | High selects configure mode, low selects access mode |
| cfg_strobe_n | input | 1 | Active-low configuration strobe; the write takes effect at its rising edge |
| rom_addr | output | 19 | Registered translated ROM address |
| rom_sel | output | 1 | Registered flag, high when the CPU address falls in a mapped region |

## Verification
A corrupted bank register cannot be seen until the CPU reads its window. The next access to that window then returns the wrong upper ROM bits, one clock after the address is applied, and the fixed region still looks correct. For this reason the stimulus sweeps every window after each series of writes, so that a write landing in the wrong window or a missed latch shows up on the next sweep. A wrong decode shows up in the same one-cycle window, either as rom_sel asserted for an unmapped address or as a window boundary off by one bit.

// File: rtl/zbm_pkg.sv
package zbm_pkg;

  // Default geometry of the mapper
  localparam int unsigned ZBM_ADDR_W  = 16;
  localparam int unsigned ZBM_ROM_W   = 19;
  localparam int unsigned ZBM_BANK_W  = 8;
  localparam int unsigned ZBM_NUM_WIN = 4;

  // Configuration strobe tracker states
  typedef enum logic {
    CFG_IDLE  = 1'b0,
    CFG_ARMED = 1'b1
  } cfg_state_e;

  // log2 of the size of window k (window 0 is the smallest)
  function automatic int unsigned win_log2(input int unsigned min_log2,
                                           input int unsigned k);
    return min_log2 + k;
  endfunction

  // Windows are packed downward from the top of the address space:
  // the largest window starts at half the space, each smaller one
  // starts where the previous one ends.
  function automatic longint unsigned win_base(input int unsigned addr_w,
                                               input int unsigned min_log2,
                                               input int unsigned k);
    return (longint'(1) << addr_w) - (longint'(1) << (min_log2 + k + 1));
  endfunction

endpackage

// File: rtl/zbm_cfg_ctrl.sv
module zbm_cfg_ctrl #(
  parameter int unsigned BANK_W = 8,
  parameter int unsigned SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_mode,
  input  logic              cfg_strobe_n,
  input  logic [BANK_W-1:0] cfg_val,
  input  logic [SEL_W-1:0]  cfg_sel,
  output logic              wr_en,
  output logic [SEL_W-1:0]  wr_sel,
  output logic [BANK_W-1:0] wr_val
);
  import zbm_pkg::*;

  logic       strb_q;
  cfg_state_e state_q;
  logic       strb_fall;
  logic       strb_rise;

  assign strb_fall = strb_q & ~cfg_strobe_n;
  assign strb_rise = ~strb_q & cfg_strobe_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_q  <= 1'b1;
      state_q <= CFG_IDLE;
    end else begin
      strb_q <= cfg_strobe_n;
      case (state_q)
        CFG_IDLE:  if (strb_fall && cfg_mode) state_q <= CFG_ARMED;
        CFG_ARMED: if (strb_rise)             state_q <= CFG_IDLE;
        default:                              state_q <= CFG_IDLE;
      endcase
    end
  end

  // Commit at the rising edge only if the pulse started in configure mode
  // and the mode is still high when it ends.
  assign wr_en  = (state_q == CFG_ARMED) && strb_rise && cfg_mode;
  assign wr_sel = cfg_sel;
  assign wr_val = cfg_val;

endmodule

// File: rtl/zbm_bank_regs.sv
module zbm_bank_regs #(
  parameter int unsigned NUM_WIN = 4,
  parameter int unsigned BANK_W  = 8,
  localparam int unsigned SEL_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [SEL_W-1:0]          wr_sel,
  input  logic [BANK_W-1:0]         wr_val,
  output logic [NUM_WIN*BANK_W-1:0] banks
);

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_bank
    logic [BANK_W-1:0] bank_q;
    always_ff @(posedge clk) begin
      if (rst)
        bank_q <= '0;
      else if (wr_en && (wr_sel == SEL_W'(k)))
        bank_q <= wr_val;
    end
    assign banks[k*BANK_W +: BANK_W] = bank_q;
  end

endmodule

// File: rtl/zbm_window_decode.sv
module zbm_window_decode #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned NUM_WIN  = 4,
  localparam int unsigned MIN_LOG2 = ADDR_W - 1 - NUM_WIN,
  localparam int unsigned HI_W     = ADDR_W - MIN_LOG2
) (
  input  logic [HI_W-1:0]    addr_hi,
  output logic               fixed_hit,
  output logic [NUM_WIN-1:0] win_hit
);
  import zbm_pkg::*;

  // Bit ADDR_W-1 of the address sits at the top of addr_hi.
  assign fixed_hit = ~addr_hi[HI_W-1];

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    localparam int unsigned     LOG2 = win_log2(MIN_LOG2, k);
    localparam int unsigned     TAG_W = ADDR_W - LOG2;
    localparam longint unsigned BASE = win_base(ADDR_W, MIN_LOG2, k);
    localparam logic [TAG_W-1:0] TAG = TAG_W'(BASE >> LOG2);
    assign win_hit[k] = (addr_hi[HI_W-1 -: TAG_W] == TAG);
  end

endmodule

// File: rtl/zbm_xlate.sv
module zbm_xlate #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned ROM_W   = 19,
  parameter int unsigned BANK_W  = 8,
  parameter int unsigned NUM_WIN = 4,
  localparam int unsigned MIN_LOG2 = ADDR_W - 1 - NUM_WIN,
  localparam int unsigned WIDE_W   = ROM_W + BANK_W + ADDR_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [NUM_WIN*BANK_W-1:0] banks,
  input  logic                      fixed_hit,
  input  logic [NUM_WIN-1:0]        win_hit,
  output logic [ROM_W-1:0]          rom_addr,
  output logic                      rom_sel
);
  import zbm_pkg::*;

  logic [ROM_W-1:0] cand [NUM_WIN];
  logic [ROM_W-1:0] addr_next;
  logic             sel_next;

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_cand
    localparam int unsigned LOG2 = win_log2(MIN_LOG2, k);
    localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'((longint'(1) << LOG2) - 1);
    // bank value above the in-window offset, cut to the ROM width
    assign cand[k] = ROM_W'((WIDE_W'(banks[k*BANK_W +: BANK_W]) << LOG2)
                            | WIDE_W'(addr & OFS_MASK));
  end

  always_comb begin
    addr_next = '0;
    if (fixed_hit) begin
      addr_next = ROM_W'(addr[ADDR_W-2:0]);
    end else begin
      for (int k = 0; k < NUM_WIN; k++) begin
        if (win_hit[k]) addr_next = addr_next | cand[k];
      end
    end
    sel_next = fixed_hit | (|win_hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr <= '0;
      rom_sel  <= 1'b0;
    end else begin
      rom_addr <= addr_next;
      rom_sel  <= sel_next;
    end
  end

endmodule

// File: rtl/zbank_mapper.sv
module zbank_mapper #(
  parameter int unsigned ADDR_W  = zbm_pkg::ZBM_ADDR_W,
  parameter int unsigned ROM_W   = zbm_pkg::ZBM_ROM_W,
  parameter int unsigned BANK_W  = zbm_pkg::ZBM_BANK_W,
  parameter int unsigned NUM_WIN = zbm_pkg::ZBM_NUM_WIN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cfg_mode,
  input  logic              cfg_strobe_n,
  output logic [ROM_W-1:0]  rom_addr,
  output logic              rom_sel
);
  localparam int unsigned SEL_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam int unsigned MIN_LOG2 = ADDR_W - 1 - NUM_WIN;
  localparam int unsigned HI_W     = ADDR_W - MIN_LOG2;

  logic                      wr_en;
  logic [SEL_W-1:0]          wr_sel;
  logic [BANK_W-1:0]         wr_val;
  logic [NUM_WIN*BANK_W-1:0] bank_flat;
  logic                      fixed_hit;
  logic [NUM_WIN-1:0]        win_hit;

  zbm_cfg_ctrl #(.BANK_W(BANK_W), .SEL_W(SEL_W)) u_cfg (
    .clk          (clk),
    .rst          (rst),
    .cfg_mode     (cfg_mode),
    .cfg_strobe_n (cfg_strobe_n),
    .cfg_val      (cpu_addr[ADDR_W-1 -: BANK_W]),
    .cfg_sel      (cpu_addr[SEL_W-1:0]),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_val       (wr_val)
  );

  zbm_bank_regs #(.NUM_WIN(NUM_WIN), .BANK_W(BANK_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_val (wr_val),
    .banks  (bank_flat)
  );

  zbm_window_decode #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN)) u_dec (
    .addr_hi   (cpu_addr[ADDR_W-1 -: HI_W]),
    .fixed_hit (fixed_hit),
    .win_hit   (win_hit)
  );

  zbm_xlate #(
    .ADDR_W(ADDR_W), .ROM_W(ROM_W), .BANK_W(BANK_W), .NUM_WIN(NUM_WIN)
  ) u_xl (
    .clk       (clk),
    .rst       (rst),
    .addr      (cpu_addr),
    .banks     (bank_flat),
    .fixed_hit (fixed_hit),
    .win_hit   (win_hit),
    .rom_addr  (rom_addr),
    .rom_sel   (rom_sel)
  );

endmodule

// File: rtl/zbank_mapper_chk.sv
module zbank_mapper_chk #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned ROM_W   = 19,
  parameter int unsigned BANK_W  = 8,
  parameter int unsigned NUM_WIN = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic [ADDR_W-1:0]         cpu_addr,
  input logic                      cfg_mode,
  input logic [ROM_W-1:0]          rom_addr,
  input logic                      rom_sel,
  input logic [NUM_WIN*BANK_W-1:0] banks
);
  logic rst_seen = 1'b0;
  logic past_ok  = 1'b0;
  logic [NUM_WIN*BANK_W-1:0] banks_q;
  logic [NUM_WIN-1:0] chg;

  always_ff @(posedge clk) begin
    rst_seen <= rst_seen | rst;
    past_ok  <= rst_seen & ~rst;
    banks_q  <= banks;
  end

  always_comb begin
    for (int k = 0; k < NUM_WIN; k++)
      chg[k] = banks[k*BANK_W +: BANK_W] != banks_q[k*BANK_W +: BANK_W];
  end

  AST_FIXED_PASS: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(cpu_addr[ADDR_W-1]) |->
      rom_sel && rom_addr == ROM_W'($past(cpu_addr[ADDR_W-2:0]))); // R1

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(&cpu_addr[ADDR_W-1 -: NUM_WIN+1]) |->
      !rom_sel && rom_addr == '0); // R6

  AST_IDLE_SEL_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rom_sel |-> rom_addr == '0); // R6

  AST_MODE_LOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(cfg_mode) |-> $stable(banks)); // R8

  AST_ONE_WINDOW: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> $countones(chg) <= 1); // R11

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    rst_seen && $past(rst) |-> banks == '0 && !rom_sel && rom_addr == '0); // R9

endmodule

bind zbank_mapper zbank_mapper_chk #(
  .ADDR_W(ADDR_W), .ROM_W(ROM_W), .BANK_W(BANK_W), .NUM_WIN(NUM_WIN)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cpu_addr (cpu_addr),
  .cfg_mode (cfg_mode),
  .rom_addr (rom_addr),
  .rom_sel  (rom_sel),
  .banks    (bank_flat)
);

// File: tb/zbank_mapper_bench.sv
module zbank_mapper_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = 16'h0000;
  logic        cfg_mode = 1'b0;
  logic        cfg_strobe_n = 1'b1;
  logic [18:0] rom_addr;
  logic        rom_sel;

  int n_run  = 0;
  int n_fail = 0;
  logic done = 1'b0;

  // bench model of the bank registers, index = window select code
  logic [7:0] mdl [4];

  always #10 clk = ~clk; // 50 MHz

  zbank_mapper u_zbank_mapper (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cfg_mode(cfg_mode),
    .cfg_strobe_n(cfg_strobe_n), .rom_addr(rom_addr), .rom_sel(rom_sel)
  );

  function automatic logic [19:0] ref_map(input logic [15:0] a);
    if (!a[15])                return {1'b1, 4'b0, a[14:0]};
    if (a[15:14] == 2'b10)     return {1'b1, mdl[3][4:0], a[13:0]};
    if (a[15:13] == 3'b110)    return {1'b1, mdl[2][5:0], a[12:0]};
    if (a[15:12] == 4'b1110)   return {1'b1, mdl[1][6:0], a[11:0]};
    if (a[15:11] == 5'b11110)  return {1'b1, mdl[0],      a[10:0]};
    return 20'h0;
  endfunction

  function automatic string req_of(input logic [15:0] a);
    if (!a[15])               return "R1";
    if (a[15:14] == 2'b10)    return "R2";
    if (a[15:13] == 3'b110)   return "R3";
    if (a[15:12] == 4'b1110)  return "R4";
    if (a[15:11] == 5'b11110) return "R5";
    return "R6";
  endfunction

  task automatic compare(input string req, input logic [19:0] exp);
    n_run++;
    if ({rom_sel, rom_addr} !== exp) begin
      n_fail++;
      $display("FAIL %s: sel/addr actual=%0h/%05h expected=%0h/%05h",
               req, rom_sel, rom_addr, exp[19], exp[18:0]);
    end
  endtask

  // apply an address and check the registered result one clock later
  task automatic access(input logic [15:0] a, input string req);
    @(negedge clk);
    cpu_addr = a;
    @(negedge clk);
    compare(req, ref_map(a));
  endtask

  task automatic access_auto(input logic [15:0] a);
    access(a, req_of(a));
  endtask

  // strobe pulse; mode can differ at the falling and rising strobe edges
  task automatic strobe_pulse(input logic [1:0] win, input logic [7:0] val,
                              input logic mode_fall, input logic mode_rise);
    @(negedge clk);
    cpu_addr = {val, 6'($urandom), win};
    cfg_mode = mode_fall;
    @(negedge clk);
    cfg_strobe_n = 1'b0;
    repeat (2) @(negedge clk);
    cfg_mode = mode_rise;
    @(negedge clk);
    cfg_strobe_n = 1'b1;
    @(negedge clk);
    cfg_mode = 1'b0;
    if (mode_fall && mode_rise) mdl[win] = val;
  endtask

  task automatic sweep_windows(input int per_win);
    logic [15:0] base [4];
    logic [15:0] mask [4];
    base[3] = 16'h8000; mask[3] = 16'h3FFF;
    base[2] = 16'hC000; mask[2] = 16'h1FFF;
    base[1] = 16'hE000; mask[1] = 16'h0FFF;
    base[0] = 16'hF000; mask[0] = 16'h07FF;
    for (int w = 0; w < 4; w++) begin
      access_auto(base[w]);
      access_auto(base[w] | mask[w]);
      for (int i = 0; i < per_win; i++)
        access_auto(base[w] | (16'($urandom) & mask[w]));
    end
  endtask

  initial begin
    int seed_val;
    seed_val = $urandom(32'd20240607);
    for (int w = 0; w < 4; w++) mdl[w] = 8'h00;

    repeat (3) @(negedge clk);
    // R9: outputs cleared while reset is held
    compare("R9", 20'h0);
    rst = 1'b0;

    // R9: every window maps through bank 0 after reset
    access(16'h8123, "R9");
    access(16'hC456, "R9");
    access(16'hE789, "R9");
    access(16'hF7FF, "R9");

    // R1 fixed region edges, R6 unmapped edges
    access(16'h0000, "R1");
    access(16'h7FFF, "R1");
    access(16'hF800, "R6");
    access(16'hFFFF, "R6");

    // R7 / R2: sequence of 16KiB bank writes, checked at window ends
    for (int b = 0; b < 32; b += 7) begin
      strobe_pulse(2'b11, 8'(b), 1'b1, 1'b1);
      access(16'h8000, "R7");
      access(16'hBFFF, "R2");
    end

    // R7 with wide values in each smaller window
    strobe_pulse(2'b10, 8'hFF, 1'b1, 1'b1);
    access(16'hC000, "R3");
    strobe_pulse(2'b01, 8'hA5, 1'b1, 1'b1);
    access(16'hEFFF, "R4");
    strobe_pulse(2'b00, 8'hFF, 1'b1, 1'b1);
    access(16'hF7FF, "R5");

    // R11: a write to one window leaves the other three unchanged
    strobe_pulse(2'b01, 8'h3C, 1'b1, 1'b1);
    access(16'h9ABC, "R11");
    access(16'hDEAD, "R11");
    access(16'hF123, "R11");
    access(16'hE456, "R11");

    // R8: mode low at the falling edge, then mode low at the rising edge
    strobe_pulse(2'b11, 8'h1E, 1'b0, 1'b1);
    access(16'hA000, "R8");
    strobe_pulse(2'b00, 8'h11, 1'b1, 1'b0);
    access(16'hF400, "R8");
    strobe_pulse(2'b10, 8'h22, 1'b0, 1'b0);
    access(16'hD000, "R8");

    // R10: output unchanged until the next clock edge, updated right after it
    access(16'h1234, "R10");
    @(negedge clk);
    cpu_addr = 16'h8765;
    #2 compare("R10", ref_map(16'h1234));
    @(posedge clk);
    #2 compare("R10", ref_map(16'h8765));

    // random writes mixed with random sweeps
    for (int it = 0; it < 24; it++) begin
      strobe_pulse(2'($urandom), 8'($urandom), 1'b1, 1'b1);
      if ((it % 6) == 5) sweep_windows(4);
    end
    sweep_windows(8);
    for (int i = 0; i < 60; i++) access_auto(16'($urandom));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule